// File: doc/BRIEF.md
# Four-Entry Instruction Translation Cache

This block is a small, fully associative translation cache with four slots. It sits between instruction fetch and a larger unified translation table. Fetch presents a virtual address, the current address-space identifier (ASID) and a flag that tells the cache to ignore the ASID. If exactly one slot matches, the block returns the physical address and the slot's attribute flags one cycle later.

On a miss the block sends one request to the unified table and waits for its answer. A single-hit answer is written into the slot chosen for eviction, and the fetch is then answered from that slot. A miss or multi-hit answer from the unified table is passed back to fetch, and the block's contents stay as they were. Recency among the four slots is held in a 6-bit code with one bit for each pair of slots.

Each slot stores a 9-bit flag word that keeps the positions used by the unified table:
- bit 8: valid
- bits {7,4}: page size, where 00 is 1 KiB, 01 is 4 KiB, 10 is 64 KiB and 11 is 1 MiB
- bit 6: user access
- bit 5: writable
- bit 3: cacheable
- bit 2: dirty
- bit 1: shared
- bit 0: write-through

Top module: `itlb_quad`

## Requirements
- R1: A slot matches when its valid bit is set, when its shared bit is set or `asid_ignore` is high or its ASID equals `cur_asid`, and when its page base equals the request address under the slot's page-size mask. For a single match, `resp_valid` and `resp_hit` go high one cycle after the request. `resp_paddr` is then (page frame AND mask) OR (address AND NOT mask), and `resp_flags` carries the slot's flags.
- R2: When more than one slot matches, `resp_multi` is reported one cycle after the request, and no unified request is issued.
- R3: When no slot matches, `ut_req_valid` pulses for one cycle, one cycle after the request, carrying the request's address, ASID and ignore flag. `busy` stays high until the fetch is answered, and requests presented while `busy` is high are ignored.
- R4: A unified answer with `ut_resp_status` = 01 (hit) is written into the victim slot. `resp_hit` follows two cycles after that answer, with the address translated through the new slot.
- R5: Flags written on a refill are masked with 0x1DA, so the dirty, writable and write-through bits read back as zero.
- R6: A use of a slot, whether by a hit or by a refill, updates the recency code as follows:
  - slot 0: code AND 0x07
  - slot 1: (code AND 0x19) OR 0x20
  - slot 2: (code AND 0x3E) OR 0x14
  - slot 3: code OR 0x0B
- R7: The victim is chosen by the first rule that applies, checked in this order:
  - slot 0 when (code AND 0x38) = 0x38
  - slot 1 when (code AND 0x26) = 0x06
  - slot 2 when (code AND 0x15) = 0x01
  - slot 3 otherwise
- R8: A unified answer with status 00 gives `resp_miss`, and status 10 or 11 gives `resp_multi`, each one cycle after the answer. Neither changes any slot or the recency code.
- R9: A high `flush_all` clears the valid bit of all four slots, so a request in the next cycle cannot hit.
- R10: Reset clears every valid bit and the recency code (victim order then starts at slot 3), and leaves all response and request outputs low.
- R11: Whenever `resp_valid` is high, exactly one of `resp_hit`, `resp_miss` and `resp_multi` is high. All three are low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_all | input | 1 | Clear all valid bits |
| req_valid | input | 1 | Fetch lookup request |
| req_vaddr | input | 32 | Fetch virtual address |
| cur_asid | input | ASID_W | Current address-space identifier |
| asid_ignore | input | 1 | Match without comparing the ASID |
| busy | output | 1 | Refill in progress; requests are ignored |
| resp_valid | output | 1 | Fetch answer valid |
| resp_hit | output | 1 | Translation found |
| resp_miss | output | 1 | No translation anywhere |
| resp_multi | output | 1 | Multiple matches |
| resp_paddr | output | 32 | Physical address |
| resp_flags | output | 9 | Flags of the matching slot |
| ut_req_valid | output | 1 | Unified-table request pulse |
| ut_req_vaddr | output | 32 | Address sent to the unified table |
| ut_req_asid | output | ASID_W | ASID sent to the unified table |
| ut_req_ignore | output | 1 | ASID-ignore flag sent to the unified table |
| ut_resp_valid | input | 1 | Unified answer valid |
| ut_resp_status | input | 2 | 00 miss, 01 hit, 1x multi-hit |
| ut_resp_vpn | input | 22 | Page base bits 31:10 |
| ut_resp_asid | input | ASID_W | Entry ASID |
| ut_resp_ppn | input | 19 | Frame bits 28:10 |
| ut_resp_flags | input | 9 | Entry flags |

## Verification
The bound checker watches several properties on every cycle:
- the response codes stay one-hot (R11);
- the unified request is a single pulse issued only while the block is busy (R3);
- no answer is given while busy (R4);
- every hit carries flags within the 0x1DA mask (R5);
- no hit follows an idle-cycle flush (R9).

The recency behaviour can only be shown by the bench's sequences. A reference model with a pairwise newer-than matrix predicts which page must miss after each eviction, over hundreds of pseudo-random page accesses (R6, R7). The bench's scenarios also cover:
- page-size address composition;
- ASID and shared matching;
- multi-match;
- unified miss and multi-hit handling, with the slots left unchanged.

// File: rtl/itlb_quad.sv
module itlb_quad #(
  parameter int ASID_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_all,
  input  logic              req_valid,
  input  logic [31:0]       req_vaddr,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              asid_ignore,
  output logic              busy,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic              resp_miss,
  output logic              resp_multi,
  output logic [31:0]       resp_paddr,
  output logic [8:0]        resp_flags,
  output logic              ut_req_valid,
  output logic [31:0]       ut_req_vaddr,
  output logic [ASID_W-1:0] ut_req_asid,
  output logic              ut_req_ignore,
  input  logic              ut_resp_valid,
  input  logic [1:0]        ut_resp_status,
  input  logic [21:0]       ut_resp_vpn,
  input  logic [ASID_W-1:0] ut_resp_asid,
  input  logic [18:0]       ut_resp_ppn,
  input  logic [8:0]        ut_resp_flags
);
  localparam int         NSLOT     = 4;
  localparam logic [8:0] KEEP_MASK = 9'h1DA;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_FILL} st_t;
  st_t st;

  logic [21:0]       e_vpn  [NSLOT];
  logic [ASID_W-1:0] e_asid [NSLOT];
  logic [18:0]       e_ppn  [NSLOT];
  logic [8:0]        e_flg  [NSLOT];
  logic [31:0]       e_mask [NSLOT];
  logic [NSLOT-1:0]  hit_vec;
  logic [5:0]        lru;
  logic [1:0]        hit_idx, victim, vic_q, sel;
  logic              multi;
  logic [31:0]       sel_va, sel_pa;

  function automatic logic [31:0] size_mask(input logic [8:0] f);
    case ({f[7], f[4]})
      2'b00:   return 32'hFFFF_FC00;
      2'b01:   return 32'hFFFF_F000;
      2'b10:   return 32'hFFFF_0000;
      default: return 32'hFFF0_0000;
    endcase
  endfunction

  function automatic logic [5:0] lru_use(input logic [5:0] v, input logic [1:0] k);
    case (k)
      2'd0:    return v & 6'h07;
      2'd1:    return (v & 6'h19) | 6'h20;
      2'd2:    return (v & 6'h3E) | 6'h14;
      default: return v | 6'h0B;
    endcase
  endfunction

  for (genvar i = 0; i < NSLOT; i++) begin : g_cmp
    assign e_mask[i]  = size_mask(e_flg[i]);
    assign hit_vec[i] = e_flg[i][8] &&
                        (e_flg[i][1] || asid_ignore || e_asid[i] == cur_asid) &&
                        ((({e_vpn[i], 10'b0} ^ req_vaddr) & e_mask[i]) == 32'b0);
  end

  always_comb begin
    hit_idx = 2'd0;
    for (int i = 0; i < NSLOT; i++)
      if (hit_vec[i]) hit_idx = 2'(i);
  end

  assign multi = (hit_vec & (hit_vec - 4'd1)) != 4'd0;

  always_comb begin
    if ((lru & 6'h38) == 6'h38)      victim = 2'd0;
    else if ((lru & 6'h26) == 6'h06) victim = 2'd1;
    else if ((lru & 6'h15) == 6'h01) victim = 2'd2;
    else                             victim = 2'd3;
  end

  assign sel    = (st == S_FILL) ? vic_q : hit_idx;
  assign sel_va = (st == S_FILL) ? ut_req_vaddr : req_vaddr;
  assign sel_pa = ({3'b0, e_ppn[sel], 10'b0} & e_mask[sel]) | (sel_va & ~e_mask[sel]);
  assign busy   = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      lru           <= 6'h00;
      vic_q         <= 2'd0;
      resp_valid    <= 1'b0;
      resp_hit      <= 1'b0;
      resp_miss     <= 1'b0;
      resp_multi    <= 1'b0;
      resp_paddr    <= 32'b0;
      resp_flags    <= 9'b0;
      ut_req_valid  <= 1'b0;
      ut_req_vaddr  <= 32'b0;
      ut_req_asid   <= '0;
      ut_req_ignore <= 1'b0;
      for (int i = 0; i < NSLOT; i++) begin
        e_vpn[i]  <= 22'b0;
        e_asid[i] <= '0;
        e_ppn[i]  <= 19'b0;
        e_flg[i]  <= 9'b0;
      end
    end else begin
      resp_valid   <= 1'b0;
      resp_hit     <= 1'b0;
      resp_miss    <= 1'b0;
      resp_multi   <= 1'b0;
      ut_req_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          if (multi) begin
            resp_valid <= 1'b1;
            resp_multi <= 1'b1;
          end else if (|hit_vec) begin
            resp_valid <= 1'b1;
            resp_hit   <= 1'b1;
            resp_paddr <= sel_pa;
            resp_flags <= e_flg[hit_idx];
            lru        <= lru_use(lru, hit_idx);
          end else begin
            ut_req_valid  <= 1'b1;
            ut_req_vaddr  <= req_vaddr;
            ut_req_asid   <= cur_asid;
            ut_req_ignore <= asid_ignore;
            st            <= S_WAIT;
          end
        end
        S_WAIT: if (ut_resp_valid) begin
          if (ut_resp_status == 2'b01) begin
            e_vpn[victim]  <= ut_resp_vpn;
            e_asid[victim] <= ut_resp_asid;
            e_ppn[victim]  <= ut_resp_ppn;
            e_flg[victim]  <= ut_resp_flags & KEEP_MASK;
            vic_q          <= victim;
            lru            <= lru_use(lru, victim);
            st             <= S_FILL;
          end else begin
            resp_valid <= 1'b1;
            resp_miss  <= (ut_resp_status == 2'b00);
            resp_multi <= (ut_resp_status != 2'b00);
            st         <= S_IDLE;
          end
        end
        default: begin
          resp_valid <= 1'b1;
          resp_hit   <= 1'b1;
          resp_paddr <= sel_pa;
          resp_flags <= e_flg[vic_q];
          st         <= S_IDLE;
        end
      endcase
      if (flush_all)
        for (int i = 0; i < NSLOT; i++) e_flg[i][8] <= 1'b0;
    end
  end
endmodule

// File: rtl/itlb_quad_chk.sv
module itlb_quad_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       flush_all,
  input logic       req_valid,
  input logic       busy,
  input logic       resp_valid,
  input logic       resp_hit,
  input logic       resp_miss,
  input logic       resp_multi,
  input logic [8:0] resp_flags,
  input logic       ut_req_valid
);
  assert_one_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $onehot({resp_hit, resp_miss, resp_multi}));
  assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid |-> !(resp_hit || resp_miss || resp_multi));
  assert_req_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ut_req_valid |=> !ut_req_valid);
  assert_req_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ut_req_valid |-> busy);
  assert_answer_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !busy);
  assert_flag_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    resp_hit |-> ((resp_flags & ~9'h1DA) == 9'h000));
  assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all && !busy) ##1 (req_valid && !busy) |=> !resp_hit);
endmodule

bind itlb_quad itlb_quad_chk u_chk (.*);

// File: tb/itlb_quad_tb.sv
module itlb_quad_tb;
  logic clk = 0, rst_n = 0;
  logic flush_all = 0, req_valid = 0, asid_ignore = 0;
  logic [31:0] req_vaddr = 0;
  logic [7:0]  cur_asid = 0;
  logic busy, resp_valid, resp_hit, resp_miss, resp_multi, ut_req_valid, ut_req_ignore;
  logic [31:0] resp_paddr, ut_req_vaddr;
  logic [8:0]  resp_flags;
  logic [7:0]  ut_req_asid;
  logic        ut_resp_valid = 0;
  logic [1:0]  ut_resp_status = 0;
  logic [21:0] ut_resp_vpn = 0;
  logic [7:0]  ut_resp_asid = 0;
  logic [18:0] ut_resp_ppn = 0;
  logic [8:0]  ut_resp_flags = 0;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m_vpn [4];
  logic [7:0]  m_asid[4];
  logic [31:0] m_ppn [4];
  logic [8:0]  m_flg [4];
  bit nw[4][4];

  always #10 clk = ~clk;

  itlb_quad u_dut (.*);

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] fmask(input logic [8:0] f);
    case ({f[7], f[4]})
      2'b00: return 32'hFFFF_FC00;
      2'b01: return 32'hFFFF_F000;
      2'b10: return 32'hFFFF_0000;
      default: return 32'hFFF0_0000;
    endcase
  endfunction

  function automatic void mlook(input logic [31:0] va, input logic [7:0] a, input bit ig,
                                output int cnt, output int idx);
    cnt = 0; idx = 0;
    for (int i = 0; i < 4; i++)
      if (m_flg[i][8] && (m_flg[i][1] || ig || m_asid[i] == a) &&
          (((m_vpn[i] ^ va) & fmask(m_flg[i])) == 0)) begin
        cnt++; idx = i;
      end
  endfunction

  function automatic void use_slot(input int k);
    for (int j = 0; j < 4; j++)
      if (j != k) begin nw[k][j] = 1; nw[j][k] = 0; end
  endfunction

  function automatic int pick_victim();
    for (int i = 0; i < 3; i++) begin
      bit all_newer = 1;
      for (int j = 0; j < 4; j++)
        if (j != i && !nw[j][i]) all_newer = 0;
      if (all_newer) return i;
    end
    return 3;
  endfunction

  task automatic flush_model();
    @(negedge clk) flush_all = 1;
    @(negedge clk) flush_all = 0;
    for (int i = 0; i < 4; i++) m_flg[i][8] = 0;
  endtask

  task automatic access(input logic [31:0] va, input logic [7:0] a, input bit ig,
                        input logic [1:0] ust, input logic [31:0] uvpn, input logic [7:0] uasid,
                        input logic [31:0] uppn, input logic [8:0] uflg, input bit poke, input string tag);
    int cnt, idx, v;
    logic [31:0] mk, exp;
    mlook(va, a, ig, cnt, idx);
    @(negedge clk);
    req_valid = 1; req_vaddr = va; cur_asid = a; asid_ignore = ig;
    @(negedge clk);
    req_valid = 0;
    if (cnt == 1) begin
      mk = fmask(m_flg[idx]);
      exp = (m_ppn[idx] & mk) | (va & ~mk);
      chk(resp_valid && resp_hit && !ut_req_valid, tag, {resp_valid, resp_hit}, 2'b11);
      chk(resp_paddr == exp, "R1 paddr", resp_paddr, exp);
      chk(resp_flags == m_flg[idx], "R1 flags", resp_flags, m_flg[idx]);
      use_slot(idx);
    end else if (cnt > 1) begin
      chk(resp_valid && resp_multi && !ut_req_valid, "R2", {resp_valid, resp_multi, ut_req_valid}, 3'b110);
    end else begin
      chk(ut_req_valid && !resp_valid, tag, {ut_req_valid, resp_valid}, 2'b10);
      chk(ut_req_vaddr == va && ut_req_asid == a && ut_req_ignore == ig && busy, "R3 request",
          {ut_req_vaddr, ut_req_asid}, {va, a});
      if (poke) begin
        req_valid = 1; req_vaddr = va ^ 32'h0010_0000;
        @(negedge clk);
        req_valid = 0;
        chk(!ut_req_valid && !resp_valid && busy, "R3 busy ignore", {ut_req_valid, resp_valid, busy}, 3'b001);
      end
      ut_resp_valid = 1; ut_resp_status = ust; ut_resp_vpn = uvpn[31:10];
      ut_resp_asid = uasid; ut_resp_ppn = uppn[28:10]; ut_resp_flags = uflg;
      @(negedge clk);
      ut_resp_valid = 0;
      if (ust == 2'b01) begin
        chk(!resp_valid, "R4 fill cycle", resp_valid, 0);
        @(negedge clk);
        mk = fmask(uflg);
        exp = ({uppn[31:10], 10'b0} & 32'h1FFF_FC00 & mk) | (va & ~mk);
        chk(resp_valid && resp_hit && resp_paddr == exp, "R4", resp_paddr, exp);
        chk(resp_flags == (uflg & 9'h1DA), "R5", resp_flags, uflg & 9'h1DA);
        v = pick_victim();
        m_vpn[v] = uvpn & 32'hFFFF_FC00; m_asid[v] = uasid;
        m_ppn[v] = uppn & 32'h1FFF_FC00; m_flg[v] = uflg & 9'h1DA;
        use_slot(v);
      end else if (ust == 2'b00) begin
        chk(resp_valid && resp_miss && !busy, "R8 miss", {resp_valid, resp_miss}, 2'b11);
      end else begin
        chk(resp_valid && resp_multi && !busy, "R8 multi", {resp_valid, resp_multi}, 2'b11);
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_flg[i] = 0; m_vpn[i] = 0; m_asid[i] = 0; m_ppn[i] = 0;
      for (int j = 0; j < 4; j++) nw[i][j] = (i < j);
    end
  end

  initial begin
    logic [31:0] seed = 32'h1234_5678;
    repeat (3) @(negedge clk);
    chk(!resp_valid && !ut_req_valid && !busy && !resp_hit && !resp_miss && !resp_multi, "R10 reset",
        {resp_valid, ut_req_valid, busy}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!resp_valid && !busy, "R10 idle", {resp_valid, busy}, 0);

    // first fill after reset lands in slot 3 (R10, R7), flags masked (R5)
    access(32'h0004_0010, 8'd5, 0, 2'b01, 32'h0004_0000, 8'd5, 32'h0C00_0000, 9'h17D, 0, "R10 R7");

    // pseudo-random page traffic over six pages: hits follow R6, evictions follow R7
    for (int n = 0; n < 400; n++) begin
      int p;
      logic [31:0] base;
      seed = seed * 32'd1103515245 + 32'd12345;
      p = int'((seed >> 16) % 6);
      base = 32'h0004_0000 + 32'(p) * 32'h1000;
      access(base | (seed & 32'hFFC), 8'd5, 0, 2'b01, base, 8'd5,
             32'h0C00_0000 + 32'(p) * 32'h3000, 9'h17D, (n % 17) == 0, "R6 R7");
    end

    // R9 flush then R1 ASID rules
    flush_model();
    access(32'h0004_0000, 8'd5, 0, 2'b00, 0, 0, 0, 0, 0, "R9");
    access(32'h0050_0000, 8'd7, 0, 2'b01, 32'h0050_0000, 8'd7, 32'h0A00_0000, 9'h150, 0, "R1");
    access(32'h0050_0010, 8'd8, 0, 2'b00, 0, 0, 0, 0, 0, "R1 asid");
    access(32'h0050_0020, 8'd8, 1, 2'b00, 0, 0, 0, 0, 0, "R1 ignore");
    access(32'h0060_0000, 8'd3, 0, 2'b01, 32'h0060_0000, 8'd3, 32'h0B00_0000, 9'h152, 0, "R1");
    access(32'h0060_0044, 8'd9, 0, 2'b00, 0, 0, 0, 0, 0, "R1 shared");

    // R1 page sizes
    flush_model();
    access(32'h0020_0400, 8'd2, 0, 2'b01, 32'h0020_0400, 8'd2, 32'h0100_0800, 9'h140, 0, "R1");
    access(32'h0020_07FC, 8'd2, 0, 2'b00, 0, 0, 0, 0, 0, "R1 1K");
    access(32'h0020_0800, 8'd2, 0, 2'b00, 0, 0, 0, 0, 0, "R8 1K edge");
    access(32'h0030_0000, 8'd2, 0, 2'b01, 32'h0030_0000, 8'd2, 32'h0120_0000, 9'h1C0, 0, "R1");
    access(32'h0030_ABCC, 8'd2, 0, 2'b00, 0, 0, 0, 0, 0, "R1 64K");
    access(32'h0100_0000, 8'd2, 0, 2'b01, 32'h0100_0000, 8'd2, 32'h050A_B400, 9'h1D0, 0, "R1");
    access(32'h010F_FFF0, 8'd2, 0, 2'b00, 0, 0, 0, 0, 0, "R1 1M");

    // R2 overlapping entries, R8 unified multi leaves contents alone
    flush_model();
    access(32'h0205_0000, 8'd1, 0, 2'b01, 32'h0205_0000, 8'd1, 32'h0300_0000, 9'h150, 0, "R1");
    access(32'h0200_0000, 8'd1, 0, 2'b01, 32'h0200_0000, 8'd1, 32'h0400_0000, 9'h1D0, 0, "R1");
    access(32'h0205_0123, 8'd1, 0, 2'b00, 0, 0, 0, 0, 0, "R2");
    access(32'h0700_0000, 8'd1, 0, 2'b10, 32'h0700_0000, 8'd1, 32'h0500_0000, 9'h150, 0, "R8");
    access(32'h0700_0000, 8'd1, 0, 2'b11, 32'h0700_0000, 8'd1, 32'h0500_0000, 9'h150, 0, "R8");
    access(32'h0200_0100, 8'd1, 0, 2'b00, 0, 0, 0, 0, 0, "R8 unchanged");
    access(32'h0205_0FFC, 8'd1, 0, 2'b00, 0, 0, 0, 0, 0, "R2 unchanged");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule